// File: doc/BRIEF.md
# Set-Associative Byte Read Cache

This block is a read-only cache placed between a requester that fetches single bytes and a slower backing memory that delivers whole blocks. Its geometry is set at elaboration by four parameters: address width, block size in bytes, capacity in bytes and number of ways. Any way count from one (direct-mapped) up to the total number of blocks (fully associative, a single set) is a legal setting.

Each accepted request is cut into a byte offset (lowest bits), a set index (the bits just above) and a tag (all remaining upper bits). The tags of every way in the chosen set are compared at once. A hit answers one cycle after acceptance. A miss sends the block-aligned address to memory, waits for the whole block in one beat, installs it and answers with the requested byte. Empty ways are filled first. When the set is full, a per-set most-recently-used pointer steers eviction to the lowest-numbered way that is not the most recent one.

Top module: `rc_cache`

## Requirements
- R1: After reset no line is valid. `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first access to any address misses.
- R2: The byte offset is the lowest log2(BLK_BYTES) address bits. The set index is the next log2(CAP_BYTES/BLK_BYTES/WAYS) bits. The tag is all bits above those. Blocks that fall in different sets never evict each other.
- R3: A request accepted while a valid line in its set holds its tag is a hit. One cycle after acceptance `rsp_valid`=1, `rsp_hit`=1 and `rsp_data` is the byte at the address's offset within that block.
- R4: On a miss, `mem_req_valid` rises one cycle after acceptance with `mem_req_addr` equal to the request address with its offset bits cleared. The request is held stable until `mem_req_ready`. `req_ready` stays 0 until the answer is given, so only one miss is ever pending.
- R5: The memory answer carries the whole block in one beat of `mem_rsp_valid`, with block byte i on `mem_rsp_data[8i+7:8i]`. One cycle later `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` is the requested byte. Later accesses to that block hit.
- R6: A miss into a set that has an invalid way installs the block in the lowest-numbered invalid way, so WAYS distinct blocks of one set all stay resident.
- R7: Each set records the way touched by its latest hit or fill as most recently used. A miss into a full set evicts the lowest-numbered way that is not that way.
- R8: With 4-byte blocks, 16-byte capacity and one way, alternating accesses to addresses 8 and 24 miss every time.
- R9: With 4-byte blocks, 16-byte capacity and two ways, the same alternation misses in its first round and hits from the second round on.
- R10: With WAYS equal to the block count, there is a single set, and any WAYS distinct blocks stay resident together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Byte address requested |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_data | output | 8 | Byte returned |
| rsp_hit | output | 1 | 1 when the answer came from a resident line |
| mem_req_valid | output | 1 | Block fetch request |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_req_addr | output | ADDR_W | Block-aligned fetch address |
| mem_rsp_valid | input | 1 | Block data beat |
| mem_rsp_data | input | 8*BLK_BYTES | Whole block, byte 0 in the low bits |

## Verification
Three instances with one, two and four ways share a block size and a capacity. An alternating pair of conflicting addresses separates the direct-mapped instance (every access misses) from the two-way one (second round hits). Four scattered blocks on the four-way instance show that a single set keeps all of them. Repeated offsets inside one resident block test byte selection apart from tag matching. A seeded random stream over a narrow address window then forces steady eviction. A bench model with its own victim rule predicts every hit flag and byte, which exposes any departure from the fill-empty-first and not-most-recently-used order.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } rc_state_e;
endpackage

// File: rtl/rc_way_cmp.sv
`timescale 1ns/1ps
module rc_way_cmp #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 13,
  parameter int WAY_W = 1
) (
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]       way_vld,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAYS-1:0]       hit_vec,
  output logic [WAY_W-1:0]      hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_vld[w] && (way_tags[w*TAG_W +: TAG_W] == tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/rc_nmru.sv
`timescale 1ns/1ps
module rc_nmru #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [WAY_W-1:0] mru,
  output logic [WAY_W-1:0] victim,
  output logic             full
);
  logic found;

  always_comb begin
    full   = &way_vld;
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !way_vld[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (full && !found && WAY_W'(w) != mru) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rc_cache.sv
`timescale 1ns/1ps
module rc_cache #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 4,
  parameter int CAP_BYTES = 16,
  parameter int WAYS      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_data,
  output logic                   rsp_hit,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [8*BLK_BYTES-1:0] mem_rsp_data
);
  import rc_pkg::*;

  localparam int LINES  = CAP_BYTES / BLK_BYTES;
  localparam int SETS   = LINES / WAYS;
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int SET_W  = (IDX_W > 0) ? IDX_W : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINE_W = 8 * BLK_BYTES;

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] line,
                                           input logic [OFF_W-1:0]  off);
    return line[{off, 3'b000} +: 8];
  endfunction

  function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  rc_state_e            state;
  logic [ADDR_W-1:0]    pend_addr;
  logic [LINE_W-1:0]    data_q [SETS][WAYS];
  logic [TAG_W-1:0]     tag_q  [SETS][WAYS];
  logic [WAYS-1:0]      vld_q  [SETS];
  logic [WAY_W-1:0]     mru_q  [SETS];

  logic [SET_W-1:0]     req_set, pend_set;
  logic [TAG_W-1:0]     req_tag, pend_tag;
  logic [OFF_W-1:0]     req_off, pend_off;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign pend_tag = pend_addr[ADDR_W-1 -: TAG_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign pend_off = pend_addr[OFF_W-1:0];

  if (IDX_W > 0) begin : g_idx
    assign req_set  = req_addr[OFF_W +: IDX_W];
    assign pend_set = pend_addr[OFF_W +: IDX_W];
  end else begin : g_one_set
    assign req_set  = '0;
    assign pend_set = '0;
  end

  // lookup across the ways of the requested set
  logic [WAYS*TAG_W-1:0] look_tags;
  logic                  look_hit;
  logic [WAYS-1:0]       hit_vec;
  logic [WAY_W-1:0]      hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign look_tags[w*TAG_W +: TAG_W] = tag_q[req_set][w];
  end

  rc_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cmp (
    .way_tags (look_tags),
    .way_vld  (vld_q[req_set]),
    .tag      (req_tag),
    .hit      (look_hit),
    .hit_vec  (hit_vec),
    .hit_way  (hit_way)
  );

  // replacement choice for the pending miss
  logic [WAY_W-1:0] fill_way;
  logic             fill_full;
  logic [WAY_W-1:0] fill_mru;

  assign fill_mru = mru_q[pend_set];

  rc_nmru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vict (
    .way_vld (vld_q[pend_set]),
    .mru     (fill_mru),
    .victim  (fill_way),
    .full    (fill_full)
  );

  // named events
  logic acc_evt, hit_evt, miss_evt, fill_evt;
  assign req_ready     = (state == ST_IDLE);
  assign acc_evt       = req_valid && req_ready;
  assign hit_evt       = acc_evt && look_hit;
  assign miss_evt      = acc_evt && !look_hit;
  assign fill_evt      = (state == ST_WAIT) && mem_rsp_valid;
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_req_addr  = block_base(pend_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_addr <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mru_q[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (hit_evt) begin
            rsp_valid        <= 1'b1;
            rsp_hit          <= 1'b1;
            rsp_data         <= pick_byte(data_q[req_set][hit_way], req_off);
            mru_q[req_set]   <= hit_way;
          end else if (miss_evt) begin
            pend_addr <= req_addr;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (fill_evt) begin
            vld_q[pend_set][fill_way] <= 1'b1;
            mru_q[pend_set]           <= fill_way;
            rsp_valid                 <= 1'b1;
            rsp_hit                   <= 1'b0;
            rsp_data                  <= pick_byte(mem_rsp_data, pend_off);
            state                     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_evt) begin
      data_q[pend_set][fill_way] <= mem_rsp_data;
      tag_q[pend_set][fill_way]  <= pend_tag;
    end
  end
endmodule

// File: rtl/rc_cache_chk.sv
`timescale 1ns/1ps
module rc_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int WAYS   = 2,
  parameter int WAY_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              hit_evt,
  input logic              fill_evt,
  input logic              fill_full,
  input logic [WAY_W-1:0]  fill_way,
  input logic [WAY_W-1:0]  fill_mru,
  input logic [WAYS-1:0]   hit_vec
);
  // R4: no new request while a fetch is pending
  p_single_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R4: fetch address is block aligned
  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R4: fetch held until taken
  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: hit answered in the following cycle
  p_hit_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (rsp_valid && rsp_hit));

  // R5: fill answered in the following cycle as a miss
  p_fill_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (rsp_valid && !rsp_hit));

  // R2: a tag lives in at most one way of a set
  p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7: a full set never evicts its most recent way
  p_victim_nmru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && fill_full && (WAYS > 1)) |-> (fill_way != fill_mru));
endmodule

bind rc_cache rc_cache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS), .WAY_W(WAY_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .hit_evt       (hit_evt),
  .fill_evt      (fill_evt),
  .fill_full     (fill_full),
  .fill_way      (fill_way),
  .fill_mru      (fill_mru),
  .hit_vec       (hit_vec)
);

// File: tb/sim_rc_cache.sv
`timescale 1ns/1ps
module sim_mem (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  logic        busy;
  int          cnt;
  logic [15:0] base;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 0; base <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0; req_ready <= 1'b0;
    end else begin
      req_ready <= ($urandom % 4) != 0;
      rsp_valid <= 1'b0;
      if (!busy && req_valid && req_ready) begin
        busy <= 1'b1; cnt <= int'($urandom % 3); base <= req_addr;
      end else if (busy) begin
        if (cnt == 0) begin
          busy <= 1'b0;
          rsp_valid <= 1'b1;
          for (int i = 0; i < 4; i++) rsp_data[8*i +: 8] <= byte_at(base + 16'(i));
        end else cnt <= cnt - 1;
      end
    end
  end
endmodule

module sim_rc_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        rv   [3];
  logic [15:0] ra   [3];
  logic        rdy  [3];
  logic        sv   [3];
  logic [7:0]  sd   [3];
  logic        sh   [3];
  logic        mrv  [3];
  logic        mrr  [3];
  logic [15:0] mra  [3];
  logic        msv  [3];
  logic [31:0] msd  [3];
  logic [15:0] cur  [3];

  rc_cache #(.ADDR_W(16), .BLK_BYTES(4), .CAP_BYTES(16), .WAYS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rdy[0]), .req_addr(ra[0]),
    .rsp_valid(sv[0]), .rsp_data(sd[0]), .rsp_hit(sh[0]), .mem_req_valid(mrv[0]),
    .mem_req_ready(mrr[0]), .mem_req_addr(mra[0]), .mem_rsp_valid(msv[0]), .mem_rsp_data(msd[0]));
  rc_cache #(.ADDR_W(16), .BLK_BYTES(4), .CAP_BYTES(16), .WAYS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rdy[1]), .req_addr(ra[1]),
    .rsp_valid(sv[1]), .rsp_data(sd[1]), .rsp_hit(sh[1]), .mem_req_valid(mrv[1]),
    .mem_req_ready(mrr[1]), .mem_req_addr(mra[1]), .mem_rsp_valid(msv[1]), .mem_rsp_data(msd[1]));
  rc_cache #(.ADDR_W(16), .BLK_BYTES(4), .CAP_BYTES(16), .WAYS(4)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[2]), .req_ready(rdy[2]), .req_addr(ra[2]),
    .rsp_valid(sv[2]), .rsp_data(sd[2]), .rsp_hit(sh[2]), .mem_req_valid(mrv[2]),
    .mem_req_ready(mrr[2]), .mem_req_addr(mra[2]), .mem_rsp_valid(msv[2]), .mem_rsp_data(msd[2]));

  sim_mem m0 (.clk(clk), .rst_n(rst_n), .req_valid(mrv[0]), .req_ready(mrr[0]), .req_addr(mra[0]),
              .rsp_valid(msv[0]), .rsp_data(msd[0]));
  sim_mem m1 (.clk(clk), .rst_n(rst_n), .req_valid(mrv[1]), .req_ready(mrr[1]), .req_addr(mra[1]),
              .rsp_valid(msv[1]), .rsp_data(msd[1]));
  sim_mem m2 (.clk(clk), .rst_n(rst_n), .req_valid(mrv[2]), .req_ready(mrr[2]), .req_addr(mra[2]),
              .rsp_valid(msv[2]), .rsp_data(msd[2]));

  // reference model: ways/sets per instance, own victim rule
  int nways [3] = '{2, 1, 4};
  int nsets [3] = '{2, 4, 1};
  bit mv [3][4][4];
  int mt [3][4][4];
  int mm [3][4];

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input int u, input logic [15:0] a, output bit hit);
    int blk, s, t, v;
    blk = int'(a) / 4;
    s = blk % nsets[u];
    t = blk / nsets[u];
    hit = 1'b0;
    for (int w = 0; w < nways[u]; w++)
      if (!hit && mv[u][s][w] && mt[u][s][w] == t) begin hit = 1'b1; mm[u][s] = w; end
    if (!hit) begin
      v = -1;
      for (int w = 0; w < nways[u]; w++) if (v < 0 && !mv[u][s][w]) v = w;
      for (int w = 0; w < nways[u]; w++) if (v < 0 && w != mm[u][s]) v = w;
      if (v < 0) v = 0;
      mv[u][s][v] = 1'b1; mt[u][s][v] = t; mm[u][s] = v;
    end
  endtask

  task automatic access(input int u, input logic [15:0] a, input string req);
    bit eh;
    logic [7:0] gd;
    logic gh;
    @(negedge clk);
    rv[u] = 1'b1; ra[u] = a; cur[u] = a;
    while (!rdy[u]) @(negedge clk);
    @(negedge clk);
    rv[u] = 1'b0;
    while (!sv[u]) @(negedge clk);
    gd = sd[u]; gh = sh[u];
    model(u, a, eh);
    check(gh == eh, req, int'(gh), int'(eh));
    check(gd == exp_byte(a), req, int'(gd), int'(exp_byte(a)));
  endtask

  task automatic expect_hit(input int u, input logic [15:0] a, input bit want, input string req);
    logic gh;
    @(negedge clk);
    rv[u] = 1'b1; ra[u] = a; cur[u] = a;
    while (!rdy[u]) @(negedge clk);
    @(negedge clk);
    rv[u] = 1'b0;
    while (!sv[u]) @(negedge clk);
    gh = sh[u];
    begin bit eh; model(u, a, eh); end
    check(gh == want, req, int'(gh), int'(want));
    check(sd[u] == exp_byte(a), req, int'(sd[u]), int'(exp_byte(a)));
  endtask

  // R4: aligned fetch of the pending block, requester blocked meanwhile
  always @(negedge clk) begin
    if (rst_n) begin
      for (int u = 0; u < 3; u++) begin
        if (mrv[u] && mrr[u]) begin
          check(mra[u] == {cur[u][15:2], 2'b00}, "R4 fetch address", int'(mra[u]),
                int'({cur[u][15:2], 2'b00}));
          check(!rdy[u], "R4 requester blocked", int'(rdy[u]), 0);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 20241;
    void'($urandom(seed));
    for (int u = 0; u < 3; u++) begin rv[u] = 1'b0; ra[u] = '0; cur[u] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    for (int u = 0; u < 3; u++) begin
      check(rdy[u] == 1'b1, "R1 ready after reset", int'(rdy[u]), 1);
      check(sv[u] == 1'b0, "R1 no answer after reset", int'(sv[u]), 0);
      check(mrv[u] == 1'b0, "R1 no fetch after reset", int'(mrv[u]), 0);
    end
    expect_hit(0, 16'h0100, 1'b0, "R1 cold miss");

    // R8: direct-mapped conflict pair thrashes
    for (int i = 0; i < 3; i++) begin
      expect_hit(1, 16'd8, 1'b0, "R8 addr 8 misses");
      expect_hit(1, 16'd24, 1'b0, "R8 addr 24 misses");
    end
    // R2: neighbouring blocks use separate sets
    expect_hit(1, 16'd0, 1'b0, "R2 set0 fill");
    expect_hit(1, 16'd4, 1'b0, "R2 set1 fill");
    expect_hit(1, 16'd1, 1'b1, "R2 set0 kept");
    expect_hit(1, 16'd6, 1'b1, "R2 set1 kept");

    // R9: two ways hold the pair after the first round
    expect_hit(0, 16'd8, 1'b0, "R9 round1 8");
    expect_hit(0, 16'd24, 1'b0, "R9 round1 24");
    expect_hit(0, 16'd8, 1'b1, "R9 round2 8");
    expect_hit(0, 16'd24, 1'b1, "R9 round2 24");
    // R3: offset selects the byte in a resident block
    expect_hit(0, 16'd9, 1'b1, "R3 offset 1");
    expect_hit(0, 16'd11, 1'b1, "R3 offset 3");
    // R7: touch 8, so 24 is the victim of 40
    expect_hit(0, 16'd10, 1'b1, "R7 touch 8");
    expect_hit(0, 16'd40, 1'b0, "R7 new block");
    expect_hit(0, 16'd8, 1'b1, "R7 mru survives");
    expect_hit(0, 16'd24, 1'b0, "R7 nmru evicted");

    // R10, R6: single set holds four scattered blocks
    expect_hit(2, 16'd0, 1'b0, "R6 fill way0");
    expect_hit(2, 16'd100, 1'b0, "R6 fill way1");
    expect_hit(2, 16'd200, 1'b0, "R6 fill way2");
    expect_hit(2, 16'd300, 1'b0, "R6 fill way3");
    expect_hit(2, 16'd2, 1'b1, "R10 block0 resident");
    expect_hit(2, 16'd101, 1'b1, "R10 block25 resident");
    expect_hit(2, 16'd203, 1'b1, "R10 block50 resident");
    expect_hit(2, 16'd300, 1'b1, "R10 block75 resident");

    // R5, R7: random stream against the model
    for (int n = 0; n < 400; n++) begin
      for (int u = 0; u < 3; u++) begin
        logic [15:0] a;
        a = 16'($urandom % 48);
        if (($urandom % 8) == 0) a = a + 16'h0400;
        access(u, a, "R5 R7 random stream");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule